// File: doc/BRIEF.md
# Polyphase Decimating FIR Filter

This block is a decimate-by-`DECIM` FIR filter with `NTAPS` fixed coefficients. It computes only the output samples that survive downsampling. Every other output is skipped outright rather than computed and thrown away. Input samples arrive on a valid/ready stream and are written into a circular history buffer. A phase counter then counts the accepted samples. When the counter wraps, which happens on every `DECIM`-th accepted sample, the block leaves its GATHER state and enters RUN. In RUN a single multiply-accumulate unit walks the `DECIM` polyphase branches one after another. Branch k uses taps k, k+DECIM, k+2·DECIM and so on. All branches read the same sample history, and each tap takes one clock, so RUN lasts `NTAPS` clocks.

While the block is in RUN, `in_ready` is low, so the history cannot be overwritten during a computation. On the last tap the block returns to GATHER and registers the full-precision sum, together with a one-clock `out_valid` pulse. The block has two states. It stays in GATHER while fewer than `DECIM` samples have been taken, and it stays in RUN while taps remain. Coefficient j sits in bits `[j*CW +: CW]` of the `COEF_BITS` parameter.

Top module: `poly_decim_fir`

## Requirements
- R1: During and right after a synchronous reset, `out_valid` is 0, `in_ready` is 1 and `out_data` is 0.
- R2: In GATHER, `in_ready` is 1. Accepting a sample that is not the DECIM-th since the last output leaves `in_ready` at 1 on the next clock.
- R3: Accepting the DECIM-th sample drops `in_ready` on the next clock. It then stays low for exactly NTAPS clocks.
- R4: `out_valid` is a one-clock pulse in the clock after the last product is added, which is the first clock in which `in_ready` is high again.
- R5: Counting accepted samples x[0], x[1], … from reset, the q-th output equals the sum over j of h[j]·x[n−j] at n = q·DECIM+DECIM−1, in two's complement at AW bits with no rounding. h[j] is the signed value in `COEF_BITS[j*CW +: CW]`.
- R6: History entries that have not been written since reset read as zero. A reset in mid-stream clears all earlier samples from later outputs.
- R7: A sample offered while `in_ready` is 0 is not taken and has no effect on any output.
- R8: `out_data` holds its value in every clock in which `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_data | input | DW | Signed input sample |
| in_ready | output | 1 | Block can take a sample this clock |
| out_valid | output | 1 | One-clock pulse marking a new output |
| out_data | output | AW | Signed full-precision filter output |

## Verification
The assertions assume that the upstream side obeys the handshake. A sample counts only when `in_valid` and `in_ready` are both high, and `rst` is synchronous. Under these assumptions the cycle count of every RUN is fixed by the design alone. The stimulus drives inputs only between clock edges. It includes stretches with `in_valid` held high through RUN, carrying distinct values that must be refused, as well as sparse random traffic, full-scale samples, and a reset issued with a partial phase pending.

// File: rtl/poly_decim_pkg.sv
package poly_decim_pkg;

    typedef enum logic [0:0] {
        ST_GATHER = 1'b0,
        ST_RUN    = 1'b1
    } fsm_state_t;

    // Step back 'back' entries from 'newest' in a ring of 'depth' entries.
    function automatic int ring_back(input int newest, input int back, input int depth);
        return (newest >= back) ? (newest - back) : (newest + depth - back);
    endfunction

endpackage

// File: rtl/poly_decim_ring.sv
module poly_decim_ring #(
    parameter int DEPTH = 12,
    parameter int DW    = 12,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic signed [DW-1:0] wr_data,
    input  logic [PW-1:0]        rd_back,
    output logic signed [DW-1:0] rd_data
);
    import poly_decim_pkg::*;

    logic signed [DW-1:0] mem_q [DEPTH];
    logic [PW-1:0]        wptr_q;
    logic [PW-1:0]        newest;
    logic [PW-1:0]        rd_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wptr_q] <= wr_data;
            wptr_q        <= (int'(wptr_q) == DEPTH - 1) ? '0 : wptr_q + 1'b1;
        end
    end

    always_comb begin
        newest  = (wptr_q == '0) ? PW'(DEPTH - 1) : wptr_q - 1'b1;
        rd_addr = PW'(ring_back(int'(newest), int'(rd_back), DEPTH));
        rd_data = mem_q[rd_addr];
    end

endmodule

// File: rtl/poly_decim_mac.sv
module poly_decim_mac #(
    parameter int DW = 12,
    parameter int CW = 12,
    parameter int AW = 28
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 first,
    input  logic signed [DW-1:0] sample,
    input  logic signed [CW-1:0] coef,
    output logic signed [AW-1:0] sum_now
);
    logic signed [DW+CW-1:0] prod;
    logic signed [AW-1:0]    acc_q;

    always_comb begin
        prod    = sample * coef;
        sum_now = (first ? '0 : acc_q) + AW'(prod);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= sum_now;
        end
    end

endmodule

// File: rtl/poly_decim_fir.sv
module poly_decim_fir #(
    parameter int NTAPS = 12,
    parameter int DECIM = 3,
    parameter int DW    = 12,
    parameter int CW    = 12,
    parameter int AW    = DW + CW + $clog2(NTAPS),
    parameter logic [NTAPS*CW-1:0] COEF_BITS = {
        12'hFE9, 12'h000, 12'h08C, 12'h184, 12'h2BE, 12'h3B6,
        12'h3B6, 12'h2BE, 12'h184, 12'h08C, 12'h000, 12'hFE9 }
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    output logic                 in_ready,
    output logic                 out_valid,
    output logic signed [AW-1:0] out_data
);
    import poly_decim_pkg::*;

    localparam int ROWS = NTAPS / DECIM;
    localparam int TW   = (NTAPS > 1) ? $clog2(NTAPS) : 1;
    localparam int PHW  = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1;

    fsm_state_t           state_q, state_d;
    logic [PHW-1:0]       phase_q;
    logic [PHW-1:0]       branch_q;
    logic [RW-1:0]        row_q;
    logic                 accept;
    logic                 phase_wrap;
    logic                 first_tap;
    logic                 last_tap;
    logic [TW-1:0]        tap;
    logic signed [DW-1:0] hist_sample;
    logic signed [CW-1:0] tap_coef;
    logic signed [AW-1:0] mac_sum;

    assign in_ready   = (state_q == ST_GATHER);
    assign accept     = in_valid && in_ready;
    assign phase_wrap = (int'(phase_q) == DECIM - 1);
    assign first_tap  = (branch_q == '0) && (row_q == '0);
    assign last_tap   = (int'(branch_q) == DECIM - 1) && (int'(row_q) == ROWS - 1);
    assign tap        = TW'(int'(branch_q) + int'(row_q) * DECIM);
    assign tap_coef   = $signed(COEF_BITS[int'(tap)*CW +: CW]);

    // Next state: GATHER -> RUN on phase wrap, RUN -> GATHER after last tap
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GATHER: if (accept && phase_wrap) state_d = ST_RUN;
            ST_RUN:    if (last_tap)             state_d = ST_GATHER;
            default:   state_d = ST_GATHER;
        endcase
    end

    // State register with phase counter and commutator counters
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_GATHER;
            phase_q  <= '0;
            branch_q <= '0;
            row_q    <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_GATHER: begin
                    if (accept) begin
                        phase_q <= phase_wrap ? '0 : phase_q + 1'b1;
                    end
                    branch_q <= '0;
                    row_q    <= '0;
                end
                ST_RUN: begin
                    if (int'(row_q) == ROWS - 1) begin
                        row_q    <= '0;
                        branch_q <= (int'(branch_q) == DECIM - 1) ? '0 : branch_q + 1'b1;
                    end else begin
                        row_q <= row_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= (state_q == ST_RUN) && last_tap;
            if ((state_q == ST_RUN) && last_tap) begin
                out_data <= mac_sum;
            end
        end
    end

    poly_decim_ring #(.DEPTH(NTAPS), .DW(DW)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept),
        .wr_data (in_data),
        .rd_back (tap),
        .rd_data (hist_sample)
    );

    poly_decim_mac #(.DW(DW), .CW(CW), .AW(AW)) u_mac (
        .clk     (clk),
        .rst     (rst),
        .en      (state_q == ST_RUN),
        .first   (first_tap),
        .sample  (hist_sample),
        .coef    (tap_coef),
        .sum_now (mac_sum)
    );

endmodule

// File: rtl/poly_decim_fir_chk.sv
module poly_decim_fir_chk #(
    parameter int NTAPS = 12,
    parameter int DECIM = 3,
    parameter int AW    = 28
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic [AW-1:0] out_data
);
    localparam int CNTW = $clog2(NTAPS + 2) + 1;
    localparam int PHW  = $clog2(DECIM + 1) + 1;

    logic [PHW-1:0]  taken_q;
    logic [CNTW-1:0] stall_q;
    logic            last_take;

    assign last_take = in_valid && in_ready && (int'(taken_q) == DECIM - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_q <= '0;
            stall_q <= '0;
        end else begin
            if (in_valid && in_ready) begin
                taken_q <= last_take ? '0 : taken_q + 1'b1;
            end
            stall_q <= in_ready ? '0 : stall_q + 1'b1;
        end
    end

    p_keep_ready_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !last_take) |=> in_ready);

    p_stall_on_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        last_take |=> !in_ready);

    p_stall_length_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ready) |-> (int'(stall_q) == NTAPS));

    p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    p_pulse_at_release_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (in_ready && int'(stall_q) == NTAPS));

    p_hold_data_r8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

endmodule

bind poly_decim_fir poly_decim_fir_chk #(.NTAPS(NTAPS), .DECIM(DECIM), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/poly_decim_fir_bench.sv
module poly_decim_fir_bench;
    localparam int NTAPS = 12;
    localparam int DECIM = 3;
    localparam int DW    = 12;
    localparam int CW    = 12;
    localparam int AW    = DW + CW + $clog2(NTAPS);
    localparam int H [NTAPS] = '{-23, 0, 140, 388, 702, 950, 950, 702, 388, 140, 0, -23};

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic                 in_ready;
    logic                 out_valid;
    logic signed [AW-1:0] out_data;

    int     checks = 0;
    int     failures = 0;
    int     hist[$];
    longint exp_q[$];
    longint last_out = 0;
    int     cd = 0;
    string  tag = "R5";

    always #10 clk = ~clk;

    poly_decim_fir #(.NTAPS(NTAPS), .DECIM(DECIM), .DW(DW), .CW(CW)) u_poly_decim_fir (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data));

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint ref_out();
        longint s = 0;
        int n = hist.size() - 1;
        for (int j = 0; j < NTAPS; j++) begin
            if (n - j >= 0) s += longint'(H[j]) * longint'(hist[n - j]);
        end
        return s;
    endfunction

    // One clock: compare at the falling edge, then drive and update the model
    task automatic step(input bit v, input int d);
        bit exp_v;
        @(negedge clk);
        exp_v = (cd == 1);
        check(cd <= 1 ? "R2" : "R3", longint'(in_ready), longint'(cd <= 1));
        check("R4", longint'(out_valid), longint'(exp_v));
        if (exp_v) begin
            last_out = exp_q.pop_front();
            check(tag, longint'(out_data), last_out);
        end else begin
            check("R8", longint'(out_data), last_out);
        end
        if (cd > 0) cd--;
        in_valid = v;
        in_data  = DW'(d);
        if (v && in_ready) begin
            hist.push_back(d);
            if (hist.size() % DECIM == 0) begin
                exp_q.push_back(ref_out());
                cd = NTAPS + 1;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        hist.delete();
        exp_q.delete();
        cd = 0;
        last_out = 0;
        check("R1", longint'(out_valid), 0);
        check("R1", longint'(in_ready), 1);
        check("R1", longint'(out_data), 0);
    endtask

    function automatic int rnd_sample();
        return int'($urandom_range(0, 4095)) - 2048;
    endfunction

    initial begin
        repeat (2) @(negedge clk);
        do_reset();

        // R5: impulse reproduces taps at decimated instants
        tag = "R5";
        step(1'b1, 1);
        for (int i = 0; i < 3 * NTAPS; i++) step(1'b1, 0);
        for (int i = 0; i < NTAPS + 3; i++) step(1'b0, 0);

        // R6: pending partial phase and old data, then reset
        for (int i = 0; i < 2 * NTAPS + 1; i++) step(1'b1, 1500 - 100 * i);
        do_reset();
        tag = "R6";
        for (int i = 0; i < 2 * NTAPS; i++) step(1'b1, 77);
        for (int i = 0; i < NTAPS + 3; i++) step(1'b0, 0);

        // R7: valid held high during RUN with distinct values
        tag = "R7";
        for (int i = 0; i < 120; i++) step(1'b1, (i * 37) % 2000 - 1000);
        for (int i = 0; i < NTAPS + 3; i++) step(1'b0, 0);

        // R5: full-scale inputs
        tag = "R5";
        for (int i = 0; i < 60; i++) step(1'b1, 2047);
        for (int i = 0; i < 60; i++) step(1'b1, -2048);
        for (int i = 0; i < 60; i++) step(1'b1, (i % 2 == 0) ? 2047 : -2048);

        // R5: sparse random traffic
        for (int i = 0; i < 600; i++) step($urandom_range(0, 1) == 1, rnd_sample());
        for (int i = 0; i < NTAPS + 4; i++) step(1'b0, 0);

        check("R5", longint'(exp_q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule